// File: doc/BRIEF.md
# Serial Memory Hold and Sleep Power Controller

This block sits beside the serial engine of a SPI slave memory and decides when that engine may move and when the data output must float. It watches the active-low pause pin and the serial clock. It latches a pause request only while the serial clock is low. While paused, the engine is frozen at its current bit and the output is disabled, so the transaction continues from the same point once the pause is released.

The block also handles a low-power state. When the opcode decoder reports the sleep opcode and the master then deasserts chip select, the block goes to sleep. It then ignores everything except chip select. The next chip-select falling edge starts a recovery window of a programmable number of system-clock cycles. During that window the output stays disabled and commands are dropped. The transaction that caused the wake-up is thrown away as a whole. The block reports ready again once recovery has finished and chip select is high.

All inputs are taken as already synchronous to the system clock. The block's outputs are an engine-advance enable, an output-disable flag and a ready flag.

Top module: `pwr_hold_sleep_ctrl`

## Requirements
- R1: After reset, ready is 1, eng_adv is 1 and out_dis is 0.
- R2: A low on hold_n, sampled while sck is low, sets the paused state. From the next cycle on, eng_adv is 0 and out_dis is 1.
- R3: While sck is high, a change on hold_n has no effect on the paused state. The change is taken only at a later cycle in which sck is low.
- R4: A high on hold_n, sampled while sck is low, clears the paused state. From the next cycle on, eng_adv is 1 and out_dis is 0, provided the block is ready.
- R5: An op_valid pulse with op_code equal to SLEEP_OP (default 8'hB9), followed by a rising edge of cs_n, puts the block to sleep. From the cycle after the rising edge, ready is 0, eng_adv is 0 and out_dis is 1.
- R6: An op_valid pulse with any other op_code, followed by a rising edge of cs_n, leaves the block ready.
- R7: While asleep, sck, hold_n and op_valid have no effect. Only a falling edge of cs_n leaves the sleep state.
- R8: A falling edge of cs_n while asleep starts recovery, which lasts RECOV_CYC cycles. During recovery, ready is 0 and out_dis is 1. If cs_n is high when recovery ends, ready returns to 1 in the (RECOV_CYC+1)-th cycle after the cycle in which cs_n was first seen low.
- R9: If cs_n is still low when recovery ends, the waking transaction is discarded. ready stays 0 until cs_n rises, and becomes 1 in the cycle after that rise.
- R10: A sleep opcode received during recovery or during a discarded transaction does not cause sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock level, already synchronous to clk |
| cs_n | input | 1 | Chip select, active low |
| hold_n | input | 1 | Pause request, active low |
| op_valid | input | 1 | One-cycle pulse: op_code holds a decoded opcode |
| op_code | input | OP_W | Opcode from the decoder |
| eng_adv | output | 1 | The serial engine may consume clock edges |
| out_dis | output | 1 | Force the data output to high impedance |
| ready | output | 1 | The block accepts commands |

## Verification
The pause path is tried with hold_n moving while sck is low and with hold_n moving while sck is high. The first case shows that the pause is taken at once. The second shows that a change made while sck is high waits for the clock to go low. Sleep entry is tried with the sleep opcode and with a plain read opcode, which tells a real sleep request apart from any chip-select rise. Wake-up is tried three ways: with a short chip-select pulse, which measures the recovery length to the cycle; with chip select held past expiry, which shows the transaction is discarded; and with pin activity and a sleep opcode sent during sleep and during recovery, which must all be ignored.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE,   // normal operation
        ST_ARMED,    // sleep opcode seen, waiting for select release
        ST_SLEEP,    // low power, only chip select watched
        ST_WAKE,     // recovery counter running
        ST_DISCARD   // recovered, waking transaction still open
    } pwr_state_e;

    function automatic logic is_sleep_op(input logic [7:0] code,
                                         input logic [7:0] ref_code);
        return code == ref_code;
    endfunction

    function automatic logic state_ready(input pwr_state_e s);
        return (s == ST_ACTIVE) || (s == ST_ARMED);
    endfunction

endpackage

// File: rtl/pwr_edge_det.sv
module pwr_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b1;
        else     sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;
endmodule

// File: rtl/pwr_hold_track.sv
module pwr_hold_track (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic hold_n,
    output logic held
);
    always_ff @(posedge clk) begin
        if (rst)       held <= 1'b0;
        else if (!sck) held <= ~hold_n;
    end
endmodule

// File: rtl/pwr_recov_timer.sv
module pwr_recov_timer #(
    parameter int RECOV_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic zero
);
    localparam int CNT_W = (RECOV_CYC < 2) ? 1 : $clog2(RECOV_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(RECOV_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (start)        cnt <= LOAD_V;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/pwr_hold_sleep_ctrl.sv
module pwr_hold_sleep_ctrl
    import pwr_pkg::*;
#(
    parameter int          OP_W      = 8,
    parameter logic [7:0]  SLEEP_OP  = 8'hB9,
    parameter int          RECOV_CYC = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sck,
    input  logic            cs_n,
    input  logic            hold_n,
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_code,
    output logic            eng_adv,
    output logic            out_dis,
    output logic            ready
);
    pwr_state_e pstate, pstate_nx;
    logic cs_rise, cs_fall, held_q, tmr_zero, tmr_start;
    logic [7:0] op_byte;

    generate
        if (OP_W >= 8) begin : g_op_trim
            assign op_byte = op_code[7:0];
        end else begin : g_op_pad
            assign op_byte = {{(8-OP_W){1'b0}}, op_code};
        end
    endgenerate

    pwr_edge_det i_cs_edge (
        .clk(clk), .rst(rst), .sig(cs_n), .rise(cs_rise), .fall(cs_fall)
    );

    pwr_hold_track i_hold (
        .clk(clk), .rst(rst), .sck(sck), .hold_n(hold_n), .held(held_q)
    );

    pwr_recov_timer #(.RECOV_CYC(RECOV_CYC)) i_tmr (
        .clk(clk), .rst(rst), .start(tmr_start), .zero(tmr_zero)
    );

    always_comb begin
        pstate_nx = pstate;
        tmr_start = 1'b0;
        unique case (pstate)
            ST_ACTIVE:
                if (op_valid && is_sleep_op(op_byte, SLEEP_OP))
                    pstate_nx = ST_ARMED;
            ST_ARMED:
                if (cs_rise) pstate_nx = ST_SLEEP;
            ST_SLEEP:
                if (cs_fall) begin
                    pstate_nx = ST_WAKE;
                    tmr_start = 1'b1;
                end
            ST_WAKE:
                if (tmr_zero) pstate_nx = cs_n ? ST_ACTIVE : ST_DISCARD;
            ST_DISCARD:
                if (cs_rise) pstate_nx = ST_ACTIVE;
            default:
                pstate_nx = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pstate <= ST_ACTIVE;
        else     pstate <= pstate_nx;
    end

    assign ready   = state_ready(pstate);
    assign eng_adv = ready & ~held_q;
    assign out_dis = held_q | ~ready;
endmodule

// File: rtl/pwr_hold_sleep_chk.sv
module pwr_hold_sleep_chk
    import pwr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sck,
    input logic       cs_n,
    input logic       hold_n,
    input logic       ready,
    input logic       eng_adv,
    input logic       held_q,
    input logic       tmr_zero,
    input pwr_state_e pstate
);
    AST_HOLD_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (!hold_n && !sck) |=> !eng_adv); // R2

    AST_HOLD_STABLE_SCK_HIGH: assert property (@(posedge clk) disable iff (rst)
        sck |=> $stable(held_q)); // R3

    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (hold_n && !sck && pstate == ST_ACTIVE) |=> eng_adv); // R4

    AST_SLEEP_ON_CS_RISE: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> ($past(cs_n) && !$past(cs_n, 2))); // R5

    AST_SLEEP_EXIT_ONLY_WAKE: assert property (@(posedge clk) disable iff (rst)
        (pstate == ST_SLEEP) |=> (pstate == ST_SLEEP || pstate == ST_WAKE)); // R7

    AST_WAKE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pstate == ST_WAKE && !tmr_zero) |=> (pstate == ST_WAKE && !ready)); // R8

    AST_DISCARD_WAITS: assert property (@(posedge clk) disable iff (rst)
        (pstate == ST_DISCARD && !cs_n) |=> !ready); // R9
endmodule

bind pwr_hold_sleep_ctrl pwr_hold_sleep_chk i_chk (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
    .ready(ready), .eng_adv(eng_adv), .held_q(held_q),
    .tmr_zero(tmr_zero), .pstate(pstate)
);

// File: tb/test_pwr_hold_sleep_ctrl.sv
module test_pwr_hold_sleep_ctrl;
    localparam int RCY = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, op_valid = 1'b0;
    logic [7:0] op_code = 8'h00;
    logic eng_adv, out_dis, ready;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwr_hold_sleep_ctrl #(.OP_W(8), .SLEEP_OP(8'hB9), .RECOV_CYC(RCY)) i_pwr_hold_sleep_ctrl (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
        .op_valid(op_valid), .op_code(op_code),
        .eng_adv(eng_adv), .out_dis(out_dis), .ready(ready)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", what, act, exp);
        end
    endtask

    task automatic send_op(input logic [7:0] code);
        op_code = code; op_valid = 1'b1;
        tick(1);
        op_valid = 1'b0;
    endtask

    task automatic go_sleep();
        cs_n = 1'b0; tick(1);
        send_op(8'hB9);
        cs_n = 1'b1; tick(1);
    endtask

    task automatic t_reset();
        chk(ready, 1'b1, "R1 ready");
        chk(eng_adv, 1'b1, "R1 eng_adv");
        chk(out_dis, 1'b0, "R1 out_dis");
    endtask

    task automatic t_hold_basic();
        cs_n = 1'b0; sck = 1'b0; hold_n = 1'b0; tick(1);
        chk(eng_adv, 1'b0, "R2 eng_adv paused");
        chk(out_dis, 1'b1, "R2 out_dis paused");
        hold_n = 1'b1; tick(1);
        chk(eng_adv, 1'b1, "R4 eng_adv resumed");
        chk(out_dis, 1'b0, "R4 out_dis resumed");
        cs_n = 1'b1; tick(1);
    endtask

    task automatic t_hold_sck_high();
        cs_n = 1'b0; sck = 1'b1; hold_n = 1'b0; tick(2);
        chk(eng_adv, 1'b1, "R3 hold ignored while sck high");
        sck = 1'b0; tick(1);
        chk(eng_adv, 1'b0, "R3 hold taken once sck low");
        sck = 1'b1; hold_n = 1'b1; tick(2);
        chk(out_dis, 1'b1, "R3 release ignored while sck high");
        sck = 1'b0; tick(1);
        chk(out_dis, 1'b0, "R4 release taken once sck low");
        cs_n = 1'b1; tick(1);
    endtask

    task automatic t_other_op();
        cs_n = 1'b0; tick(1);
        send_op(8'h03);
        cs_n = 1'b1; tick(3);
        chk(ready, 1'b1, "R6 non-sleep opcode");
    endtask

    task automatic t_sleep_and_wake();
        go_sleep();
        chk(ready, 1'b0, "R5 ready asleep");
        chk(eng_adv, 1'b0, "R5 eng_adv asleep");
        chk(out_dis, 1'b1, "R5 out_dis asleep");
        // pin activity while asleep
        sck = 1'b1; tick(1); sck = 1'b0; hold_n = 1'b0; tick(1);
        send_op(8'h06); hold_n = 1'b1; tick(2);
        chk(ready, 1'b0, "R7 still asleep after pin activity");
        // short wake pulse, measure recovery length
        cs_n = 1'b0; tick(1);
        chk(ready, 1'b0, "R8 ready low at wake start");
        cs_n = 1'b1; tick(RCY - 1);
        chk(ready, 1'b0, "R8 ready low at last recovery cycle");
        chk(out_dis, 1'b1, "R8 out_dis during recovery");
        tick(1);
        chk(ready, 1'b1, "R8 ready after recovery");
        chk(out_dis, 1'b0, "R8 out_dis after recovery");
    endtask

    task automatic t_wake_discard();
        go_sleep();
        cs_n = 1'b0; tick(3);
        send_op(8'hB9);   // sleep opcode inside recovery
        tick(RCY + 2);
        send_op(8'hB9);   // sleep opcode inside discarded transaction
        chk(ready, 1'b0, "R9 waking transaction discarded");
        cs_n = 1'b1; tick(1);
        chk(ready, 1'b1, "R9 ready after select release");
        tick(3);
        chk(ready, 1'b1, "R10 opcode during wake ignored");
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_hold_basic();
        t_hold_sck_high();
        t_other_op();
        t_sleep_and_wake();
        t_wake_discard();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                tick(5000);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule